// File: doc/BRIEF.md
# Trace Frame Unpacker

This block sits between a trace capture memory and a trace decoder. Each 32-bit word read out of the memory holds one, two or three cycles of trace port samples, depending on how wide the trace port was when the samples were captured. The unpacker cuts every word into per-cycle entries and passes them on one at a time. Each entry holds a 3-bit pipeline status, a packet field zero-extended to 16 bits, a sync flag and a trigger flag. When a sample's pipeline status carries the trigger code, the entry instead reports the status held in the low bits of that sample's packet field, and it raises the trigger flag.

Words enter on a valid/ready stream and entries leave on another valid/ready stream. The path is combinational, so no entry is stored inside the block. An entry is offered whenever an input word is offered. The downstream side stalls the block by holding `ent_ready` low. While it does, the same entry stays on the outputs and the slot counter does not move. The input word is consumed (`word_ready` high) only in the cycle in which the last entry of that word is accepted. The upstream side must keep the word stable while `word_valid` is high and the word has not been consumed. The port-width select `port_mode` is static and may change only while no word is being offered.

Top module: `trace_unpack`

## Requirements
- R1: With `port_mode` = 2'b00 (4-bit port), a word yields three entries at bit offsets 0, 8 and 16. For an entry at offset o, the raw status is bits o+2..o, the packet is bits o+6..o+3, and the sync flag is bit o+7.
- R2: With `port_mode` = 2'b01 (8-bit port), a word yields two entries at bit offsets 0 and 12. For an entry at offset o, the raw status is bits o+2..o, the packet is bits o+10..o+3, and the sync flag is bit o+11.
- R3: With `port_mode` = 2'b10 (16-bit port), a word yields one entry. Its raw status is bits 2..0, its packet is bits 18..3, and its sync flag is bit 19.
- R4: When the raw status of an entry equals 3'b110, `ent_pstat` shows packet bits 2..0 and `ent_trig` is 1. Otherwise `ent_pstat` shows the raw status and `ent_trig` is 0.
- R5: The entries of one word leave in order of rising bit offset, and each accepted entry moves the block to the next offset.
- R6: `word_ready` is high only while `ent_ready` is high and the entry on offer is the last entry of the current word. In every other cycle the word is held.
- R7: Packet fields narrower than 16 bits appear on `ent_pkt` with all upper bits zero.
- R8: While `ent_valid` is high and `ent_ready` is low, the offered entry stays unchanged and the position within the word does not move.
- R9: After reset the block starts at the first entry of a word, and `ent_valid` equals `word_valid`.
- R10: `port_mode` = 2'b11 behaves exactly like the 16-bit port setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_mode | input | 2 | Trace port width select: 00 = 4-bit, 01 = 8-bit, 10 or 11 = 16-bit |
| word_valid | input | 1 | Input word offered |
| word_data | input | 32 | Packed trace word |
| word_ready | output | 1 | Input word consumed this cycle |
| ent_valid | output | 1 | Entry offered |
| ent_ready | input | 1 | Downstream accepts the entry |
| ent_pstat | output | 3 | Pipeline status, with trigger substitution applied |
| ent_pkt | output | 16 | Packet field, zero-extended |
| ent_sync | output | 1 | Sync flag of this cycle |
| ent_trig | output | 1 | Trigger marker seen in this cycle |

## Verification
The bench sweeps all four port-mode codes over words that put the trigger code in every slot, words of all ones and all zeros, and pseudo-random words. For each entry it computes the expected fields from the bit offsets. A slot counter that skipped or repeated an entry would show the wrong fields on a later entry. A design that applied the trigger substitution to the wrong bits, or let upper packet bits leak through, would show mismatched `ent_pstat` or `ent_pkt` values. Stall patterns of zero to two cycles are placed before each entry, so a design that advanced during a stall, or that released the word before its last entry, fails both the field checks and the `word_ready` checks.

// File: rtl/trace_unpack_pkg.sv
package trace_unpack_pkg;

  localparam int PKT_W  = 16;
  localparam int PST_W  = 3;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    PW_4   = 2'b00,
    PW_8   = 2'b01,
    PW_16  = 2'b10,
    PW_16B = 2'b11
  } port_mode_e;

  typedef struct packed {
    logic [PST_W-1:0] pstat;
    logic [PKT_W-1:0] pkt;
    logic             sync;
    logic             trig;
  } entry_t;

  // number of entries packed in one word for a given port mode
  function automatic logic [SLOT_W-1:0] slots_per_word(port_mode_e m);
    case (m)
      PW_4:    return SLOT_W'(3);
      PW_8:    return SLOT_W'(2);
      default: return SLOT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/tu_slot_extract.sv
module tu_slot_extract
  import trace_unpack_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  port_mode_e        mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  output entry_t            raw_o
);
  localparam int OFF_W = $clog2(WORD_W);
  localparam int RAW_W = PST_W + PKT_W + 1;

  logic [OFF_W-1:0] off;
  logic [RAW_W-1:0] raw;

  // bit offset of the selected slot: 8 per slot for 4-bit, 12 per slot for 8-bit
  always_comb begin
    case (mode_i)
      PW_4:    off = OFF_W'({slot_i, 3'b000});
      PW_8:    off = OFF_W'({slot_i, 3'b000}) + OFF_W'({slot_i, 2'b00});
      default: off = '0;
    endcase
  end

  assign raw = RAW_W'(word_i >> off);

  always_comb begin
    raw_o       = '0;
    raw_o.pstat = raw[PST_W-1:0];
    case (mode_i)
      PW_4: begin
        raw_o.pkt  = PKT_W'(raw[PST_W+3:PST_W]);
        raw_o.sync = raw[PST_W+4];
      end
      PW_8: begin
        raw_o.pkt  = PKT_W'(raw[PST_W+7:PST_W]);
        raw_o.sync = raw[PST_W+8];
      end
      default: begin
        raw_o.pkt  = raw[PST_W+PKT_W-1:PST_W];
        raw_o.sync = raw[PST_W+PKT_W];
      end
    endcase
  end

endmodule

// File: rtl/tu_trig_fix.sv
module tu_trig_fix
  import trace_unpack_pkg::*;
#(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  entry_t raw_i,
  output entry_t ent_o
);
  always_comb begin
    ent_o      = raw_i;
    ent_o.trig = 1'b0;
    if (raw_i.pstat == TRIG_CODE) begin
      ent_o.pstat = raw_i.pkt[PST_W-1:0];
      ent_o.trig  = 1'b1;
    end
  end
endmodule

// File: rtl/tu_slot_seq.sv
module tu_slot_seq
  import trace_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  port_mode_e        mode_i,
  input  logic              in_valid_i,
  input  logic              out_ready_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              in_ready_o,
  output logic              out_valid_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] last_slot;
  logic              at_last;
  logic              take;

  assign last_slot   = slots_per_word(mode_i) - SLOT_W'(1);
  assign at_last     = (slot_q >= last_slot);
  assign out_valid_o = in_valid_i;
  assign in_ready_o  = out_ready_i && at_last;
  assign take        = in_valid_i && out_ready_i;
  assign slot_o      = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (take)    slot_q <= at_last ? '0 : slot_q + SLOT_W'(1);
  end

  // R6: once a word is consumed the next one starts at its first slot
  a_r6_word_restart: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && in_ready_o |=> slot_q == '0);

  // R5: an accepted entry that is not the last moves one slot up
  a_r5_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && out_ready_i && !in_ready_o |=> slot_q == $past(slot_q) + SLOT_W'(1));

  // R8: a stalled entry keeps its slot
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> $stable(slot_q));

  // R6: word release requires downstream acceptance
  a_r6_ready_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> out_ready_i);

endmodule

// File: rtl/trace_unpack.sv
module trace_unpack
  import trace_unpack_pkg::*;
#(
  parameter int         WORD_W    = 32,
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        port_mode,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic [PST_W-1:0]  ent_pstat,
  output logic [PKT_W-1:0]  ent_pkt,
  output logic              ent_sync,
  output logic              ent_trig
);
  port_mode_e        mode;
  logic [SLOT_W-1:0] slot;
  entry_t            raw_ent;
  entry_t            ent;

  assign mode = port_mode_e'(port_mode);

  tu_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .in_valid_i (word_valid),
    .out_ready_i(ent_ready),
    .slot_o     (slot),
    .in_ready_o (word_ready),
    .out_valid_o(ent_valid)
  );

  tu_slot_extract #(.WORD_W(WORD_W)) u_extract (
    .word_i(word_data),
    .mode_i(mode),
    .slot_i(slot),
    .raw_o (raw_ent)
  );

  tu_trig_fix #(.TRIG_CODE(TRIG_CODE)) u_trig (
    .raw_i(raw_ent),
    .ent_o(ent)
  );

  assign ent_pstat = ent.pstat;
  assign ent_pkt   = ent.pkt;
  assign ent_sync  = ent.sync;
  assign ent_trig  = ent.trig;

  // R7: narrow packet fields reach the port zero-extended
  a_r7_zext_4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && mode == PW_4 |-> ent_pkt[PKT_W-1:4] == '0);
  a_r7_zext_8: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && mode == PW_8 |-> ent_pkt[PKT_W-1:8] == '0);

  // R8: a stalled entry keeps its fields while the word is held
  a_r8_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> !word_valid || ($stable(ent_pstat) && $stable(ent_pkt)
                                               && $stable(ent_sync) && $stable(ent_trig)));

endmodule

// File: tb/trace_unpack_bench.sv
module trace_unpack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS_PER_MODE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  port_mode = 2'b00;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready;
  logic        ent_valid;
  logic        ent_ready = 1'b0;
  logic [2:0]  ent_pstat;
  logic [15:0] ent_pkt;
  logic        ent_sync;
  logic        ent_trig;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_unpack u_trace_unpack (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_pstat(ent_pstat), .ent_pkt(ent_pkt), .ent_sync(ent_sync), .ent_trig(ent_trig)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int n_slots(int m);
    return (m == 0) ? 3 : (m == 1) ? 2 : 1;
  endfunction

  // expected {pstat, pkt, sync, trig} from the offsets of R1..R4, R7, R10
  function automatic logic [31:0] exp_entry(logic [31:0] w, int m, int k);
    int off, wid;
    logic [31:0] r, ps, pk, sy, tr;
    if (m == 0)      begin off = k * 8;  wid = 4;  end
    else if (m == 1) begin off = k * 12; wid = 8;  end
    else             begin off = 0;      wid = 16; end
    r  = w >> off;
    ps = r & 32'd7;
    pk = (r >> 3) & ((32'd1 << wid) - 32'd1);
    sy = (r >> (3 + wid)) & 32'd1;
    tr = 0;
    if (ps == 32'd6) begin ps = pk & 32'd7; tr = 1; end
    return {11'b0, ps[2:0], pk[15:0], sy[0], tr[0]};
  endfunction

  function automatic logic [31:0] got_entry();
    return {11'b0, ent_pstat, ent_pkt, ent_sync, ent_trig};
  endfunction

  function automatic string req_of(int m);
    return (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R10";
  endfunction

  task automatic send_word(input logic [31:0] w, input int m, input int seed);
    for (int k = 0; k < n_slots(m); k++) begin
      for (int s = 0; s < (seed + k) % 3; s++) begin
        @(negedge clk);
        word_valid = 1'b1; word_data = w; ent_ready = 1'b0;
        #1;
        chk("R8 valid during stall", {31'b0, ent_valid}, 32'd1);
        chk("R8 entry held during stall", got_entry(), exp_entry(w, m, k));
        chk("R6 word held during stall", {31'b0, word_ready}, 32'd0);
      end
      @(negedge clk);
      word_valid = 1'b1; word_data = w; ent_ready = 1'b1;
      #1;
      chk({req_of(m), " R4 R5 R7 entry fields"}, got_entry(), exp_entry(w, m, k));
      chk("R6 word_ready on last slot only", {31'b0, word_ready},
          {31'b0, (k == n_slots(m) - 1)});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    @(negedge clk);
    port_mode = 2'b00; word_valid = 1'b0; ent_ready = 1'b1;
    #1;
    chk("R9 no entry without word", {31'b0, ent_valid}, 32'd0);
    @(negedge clk);
    word_valid = 1'b1; word_data = 32'h00AB_CDEF;
    #1;
    chk("R9 valid follows word", {31'b0, ent_valid}, 32'd1);
    chk("R9 starts at first slot", got_entry(), exp_entry(32'h00AB_CDEF, 0, 0));
    chk("R9 R6 first slot not last", {31'b0, word_ready}, 32'd0);
    ent_ready = 1'b0;
    // finish this word cleanly from slot 0 (no edge accepted yet)
    send_word(32'h00AB_CDEF, 0, 0);

    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      word_valid = 1'b0; ent_ready = 1'b0;
      port_mode = 2'(m);
      for (int i = 0; i < WORDS_PER_MODE; i++) begin
        logic [31:0] w;
        case (i)
          0: w = 32'h0000_0000;
          1: w = 32'hFFFF_FFFF;
          2: w = 32'h0036_2E16;   // trigger code in every 4-bit slot
          3: w = 32'h0016_E0B6;   // trigger code at offsets 0 and 12
          4: w = 32'h0004_D2F6;   // trigger code with 16-bit packet
          5: w = 32'hFF8F_F80E;
          default: begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            w = lfsr;
          end
        endcase
        send_word(w, m, i);
      end
    end

    // R8 R6: idle with no word, downstream ready, nothing offered
    @(negedge clk);
    word_valid = 1'b0; ent_ready = 1'b1;
    #1;
    chk("R9 no entry when idle", {31'b0, ent_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule